// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block runs the low-power direction handover on one bidirectional serial data lane. The lane is a pair of single-ended lines, P and N. Exactly one end of the link drives the pair at a time. When this end owns the lane and the `ta_req` input is asserted, the block plays a timed line sequence, then tri-states its drivers and listens. When this end is listening and it sees the far side start a handover, it waits a settling interval, takes over the pair, plays its own timed sequence, and reports that it now owns the lane.

Every interval is a whole multiple of one programmed unit, `lpx_ticks`, counted in cycles of `clk`. Each phase length is computed from `lpx_ticks` at the moment that phase starts. The block can therefore be retimed between handovers without any other change. Escape commands and high-speed bursts belong to other logic.

Top module: `lp_ta_ctrl`

## Requirements
- R1: Synchronous reset puts the block into the owner-idle state with `is_owner`=1, `lp_oe`=1 and `lp_out`=2'b11, from the first clock edge with `rst` high. This holds even in the middle of a sequence.
- R2: `lp_out[1]` is the P line and `lp_out[0]` is the N line. The line state P=1, N=0 is therefore 2'b10. If `ta_req` is high at a clock edge while the block is owner-idle, then starting with that edge it drives 2'b11 for L cycles, then 2'b10 for L cycles, then 2'b00 for exactly 4·L cycles. After that it enters receive: `lp_oe`=0, `is_owner`=0, `lp_out` parked at 2'b11.
- R3: In receive, a clock edge at which `lp_in`=2'b10 and the previous edge's sample was 2'b11 starts a takeover. The block then keeps `lp_oe`=0 for S = L + floor(L/2) cycles, counted from that edge.
- R4: After the wait in R3, the block drives 2'b00 with `lp_oe`=1 for exactly 5·L cycles. `is_owner` stays 0 during this hold.
- R5: After the hold in R4, it drives 2'b10 for L cycles. It then drives 2'b11 with `is_owner`=1 and is owner-idle again.
- R6: `ta_req` has no effect at any time other than owner-idle: not while releasing, not in receive, and not while taking over.
- R7: `lp_in` has no effect while the block owns the lane, whether it is idle or releasing.
- R8: In receive, `lp_in`=2'b10 that was not preceded by a 2'b11 sample does not start a takeover.
- R9: L is the value of `lpx_ticks` when each phase begins. A value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lpx_ticks | input | CNT_W | Length of one low-power unit in clock cycles |
| ta_req | input | 1 | Request to hand the lane to the far side |
| lp_in | input | 2 | Sampled line pair {P, N} |
| lp_out | output | 2 | Driven line pair {P, N} |
| lp_oe | output | 1 | Line driver enable |
| is_owner | output | 1 | High while this end owns the lane and is idle |

## Verification
All outputs are registered from the next state. A change caused by an input sampled at edge e is therefore visible just after edge e, with no extra register stage. A phase of length N that starts at edge e ends at edge e+N. The bench drives inputs at falling edges. It counts rising edges from the edge that took the request or the trigger, and compares `{is_owner, lp_oe, lp_out}` at every falling edge against a profile built from L and S. Both ends of every phase are checked cycle-exactly.

// File: rtl/lp_ta_pkg.sv
package lp_ta_pkg;

  typedef enum logic [2:0] {
    ST_OWN   = 3'd0,
    ST_REL11 = 3'd1,
    ST_REL10 = 3'd2,
    ST_GO    = 3'd3,
    ST_RX    = 3'd4,
    ST_SURE  = 3'd5,
    ST_GET   = 3'd6,
    ST_ACQ10 = 3'd7
  } ta_state_e;

  typedef enum logic [1:0] {
    LEN_X1   = 2'd0,
    LEN_X4   = 2'd1,
    LEN_X5   = 2'd2,
    LEN_SURE = 2'd3
  } len_kind_e;

  typedef struct packed {
    logic       owner;
    logic       oe;
    logic [1:0] line;
  } drive_t;

  localparam logic [1:0] LINE_11 = 2'b11;
  localparam logic [1:0] LINE_10 = 2'b10;
  localparam logic [1:0] LINE_00 = 2'b00;

  function automatic drive_t drive_of(input ta_state_e st);
    drive_t d;
    case (st)
      ST_OWN:   d = '{owner: 1'b1, oe: 1'b1, line: LINE_11};
      ST_REL11: d = '{owner: 1'b0, oe: 1'b1, line: LINE_11};
      ST_REL10: d = '{owner: 1'b0, oe: 1'b1, line: LINE_10};
      ST_GO:    d = '{owner: 1'b0, oe: 1'b1, line: LINE_00};
      ST_GET:   d = '{owner: 1'b0, oe: 1'b1, line: LINE_00};
      ST_ACQ10: d = '{owner: 1'b0, oe: 1'b1, line: LINE_10};
      default:  d = '{owner: 1'b0, oe: 1'b0, line: LINE_11};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ta_phase_len.sv
module ta_phase_len
  import lp_ta_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int LEN_W = CNT_W + 3
) (
  input  logic [CNT_W-1:0] lpx_ticks,
  input  len_kind_e        kind,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] unit;

  always_comb begin
    unit = (lpx_ticks == '0) ? LEN_W'(1) : LEN_W'(lpx_ticks);
    case (kind)
      LEN_X4:   len = unit << 2;
      LEN_X5:   len = (unit << 2) + unit;
      LEN_SURE: len = unit + (unit >> 1);
      default:  len = unit;
    endcase
  end
endmodule

// File: rtl/ta_hold_timer.sv
module ta_hold_timer #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len - LEN_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ta_line_watch.sv
module ta_line_watch
  import lp_ta_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lp_in,
  output logic       trig
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= LINE_00;
    else     prev_q <= lp_in;
  end

  assign trig = (lp_in == LINE_10) && (prev_q == LINE_11);
endmodule

// File: rtl/lp_ta_ctrl.sv
module lp_ta_ctrl
  import lp_ta_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] lpx_ticks,
  input  logic             ta_req,
  input  logic [1:0]       lp_in,
  output logic [1:0]       lp_out,
  output logic             lp_oe,
  output logic             is_owner
);
  localparam int LEN_W = CNT_W + 3;

  ta_state_e        state_q, state_d;
  len_kind_e        kind;
  logic             load;
  logic             done;
  logic             trig;
  logic [LEN_W-1:0] len;
  drive_t           drv_d;

  ta_phase_len #(.CNT_W(CNT_W)) u_len (
    .lpx_ticks (lpx_ticks),
    .kind      (kind),
    .len       (len)
  );

  ta_hold_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .len  (len),
    .done (done)
  );

  ta_line_watch u_watch (
    .clk   (clk),
    .rst   (rst),
    .lp_in (lp_in),
    .trig  (trig)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    kind    = LEN_X1;
    case (state_q)
      ST_OWN:   if (ta_req) begin state_d = ST_REL11; load = 1'b1; kind = LEN_X1;   end
      ST_REL11: if (done)   begin state_d = ST_REL10; load = 1'b1; kind = LEN_X1;   end
      ST_REL10: if (done)   begin state_d = ST_GO;    load = 1'b1; kind = LEN_X4;   end
      ST_GO:    if (done)   begin state_d = ST_RX;                                  end
      ST_RX:    if (trig)   begin state_d = ST_SURE;  load = 1'b1; kind = LEN_SURE; end
      ST_SURE:  if (done)   begin state_d = ST_GET;   load = 1'b1; kind = LEN_X5;   end
      ST_GET:   if (done)   begin state_d = ST_ACQ10; load = 1'b1; kind = LEN_X1;   end
      ST_ACQ10: if (done)   begin state_d = ST_OWN;                                 end
      default:              begin state_d = ST_OWN;                                 end
    endcase
  end

  assign drv_d = drive_of(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OWN;
      lp_out   <= LINE_11;
      lp_oe    <= 1'b1;
      is_owner <= 1'b1;
    end else begin
      state_q  <= state_d;
      lp_out   <= drv_d.line;
      lp_oe    <= drv_d.oe;
      is_owner <= drv_d.owner;
    end
  end
endmodule

// File: rtl/lp_ta_ctrl_chk.sv
module lp_ta_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ta_req,
  input logic [1:0] lp_out,
  input logic       lp_oe,
  input logic       is_owner
);
  // R5
  owner_drives_chk: assert property (@(posedge clk) disable iff (rst)
    is_owner |-> (lp_oe && lp_out == 2'b11));

  // R2
  release_from_bridge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lp_oe) |-> ($past(lp_out) == 2'b00 && !is_owner));

  // R4
  takeover_bridge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_oe) |-> (lp_out == 2'b00 && !is_owner));

  // R5
  owner_after_10_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(is_owner) |-> ($past(lp_out) == 2'b10 && $past(lp_oe)));

  // R2
  release_starts_11_chk: assert property (@(posedge clk) disable iff (rst)
    (is_owner && ta_req) |=> (!is_owner && lp_oe && lp_out == 2'b11));
endmodule

bind lp_ta_ctrl lp_ta_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ta_req   (ta_req),
  .lp_out   (lp_out),
  .lp_oe    (lp_oe),
  .is_owner (is_owner)
);

// File: tb/lp_ta_ctrl_bench.sv
module lp_ta_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int NVEC = 6;
  localparam int LPX_TAB [NVEC] = '{1, 2, 3, 4, 5, 7};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] lpx_ticks = CNT_W'(1);
  logic             ta_req = 1'b0;
  logic [1:0]       lp_in = 2'b11;
  logic [1:0]       lp_out;
  logic             lp_oe;
  logic             is_owner;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_ta_ctrl #(.CNT_W(CNT_W)) u_lp_ta_ctrl (
    .clk       (clk),
    .rst       (rst),
    .lpx_ticks (lpx_ticks),
    .ta_req    (ta_req),
    .lp_in     (lp_in),
    .lp_out    (lp_out),
    .lp_oe     (lp_oe),
    .is_owner  (is_owner)
  );

  task automatic check(input string req, input logic [3:0] expv);
    logic [3:0] got;
    got = {is_owner, lp_oe, lp_out};
    n_vec++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s at %0t: got {owner,oe,line}=%b expected %b", req, $time, got, expv);
    end
  endtask

  function automatic logic [3:0] exp_rel(input int m, input int l);
    if (m <= l)     return 4'b0111;
    if (m <= 2*l)   return 4'b0110;
    if (m <= 6*l)   return 4'b0100;
    return 4'b0011;
  endfunction

  function automatic logic [3:0] exp_acq(input int m, input int l);
    int s;
    s = l + l/2;
    if (m <= s)       return 4'b0011;
    if (m <= s + 5*l) return 4'b0100;
    if (m <= s + 6*l) return 4'b0110;
    return 4'b1111;
  endfunction

  function automatic string tag_rel(input int m, input int l);
    if (m <= 6*l) return "R2 release";
    return "R2 receive";
  endfunction

  function automatic string tag_acq(input int m, input int l);
    int s;
    s = l + l/2;
    if (m <= s)       return "R3 sure wait";
    if (m <= s + 5*l) return "R4 bridge hold";
    return "R5 hand-back";
  endfunction

  // Release: ta_req sampled at edge e; m counts edges from e inclusive.
  task automatic run_release(input int l, input bit hold_req);
    ta_req = 1'b1;
    lp_in  = 2'b11;
    @(negedge clk);
    for (int m = 1; m <= 6*l + 1; m++) begin
      if (!hold_req) ta_req = 1'b0;
      if (m == 2) lp_in = 2'b10;  // R7: ignored while owning
      if (m == 3) lp_in = 2'b00;
      check(tag_rel(m, l), exp_rel(m, l));
      if (m < 6*l + 1) @(negedge clk);
    end
    ta_req = 1'b0;
  endtask

  task automatic run_acquire(input int l);
    lp_in = 2'b11;
    @(negedge clk);
    lp_in = 2'b10;
    @(negedge clk);
    for (int m = 1; m <= l + l/2 + 6*l + 1; m++) begin
      if (m == 2) begin lp_in = 2'b11; ta_req = 1'b1; end  // R6: ignored
      if (m == 3) ta_req = 1'b0;
      check(tag_acq(m, l), exp_acq(m, l));
      if (m < l + l/2 + 6*l + 1) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 4'b1111);

    for (int i = 0; i < NVEC; i++) begin
      lpx_ticks = CNT_W'(LPX_TAB[i]);
      run_release(LPX_TAB[i], (i % 2) == 1);  // odd rows hold ta_req: R6
      for (int k = 0; k < 3; k++) begin
        ta_req = 1'b1;  // R6: request in receive is ignored
        @(negedge clk);
        check("R6 req in receive", 4'b0011);
      end
      ta_req = 1'b0;
      run_acquire(LPX_TAB[i]);
      @(negedge clk);
    end

    // R7: line activity while owner-idle
    lp_in = 2'b11;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      lp_in = 2'b10;
      @(negedge clk);
      check("R7 lp_in ignored when owner", 4'b1111);
    end

    // R9: zero unit behaves as one
    lpx_ticks = '0;
    run_release(1, 1'b0);

    // R8: 10 not preceded by 11 does not trigger
    lp_in = 2'b00;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      lp_in = 2'b10;
      @(negedge clk);
      check("R8 no trigger without 11", 4'b0011);
    end
    run_acquire(1);  // R9 zero unit on takeover
    @(negedge clk);

    // R1: reset in the middle of a release
    lpx_ticks = CNT_W'(3);
    ta_req = 1'b1;
    @(negedge clk);
    ta_req = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 mid-release state", 4'b0110);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-sequence", 4'b1111);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 4'b1111);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule